// File: doc/BRIEF.md
# Serial Byte Transmitter with Half-Duplex Line Direction

This block sends bytes as asynchronous serial frames. Each frame is eight data bits with no parity and one stop bit. A byte stream enters through a valid/ready port and waits in a small queue. A frame engine takes the bytes from the queue one at a time and shifts each one out. The engine advances on a 16x oversampling tick.

The block also drives a direction output for a half-duplex bus transceiver and raises a transmit interrupt. A mode input, `auto_dir`, selects how both of these behave:
- **Standard mode** (`auto_dir` low): the direction output stays low. The interrupt rises as soon as the queue drains, even while the last frame is still on the line.
- **Automatic mode** (`auto_dir` high): the interrupt waits until the frame engine is also empty. The direction output goes high one full bit time after the last stop bit, which turns the transceiver around to receive. It drops again when the next byte is accepted.

Back-pressure rules on the write port:
- A byte is taken on any rising clock edge where `wr_valid` and `wr_ready` are both high.
- `wr_ready` is low only while the queue holds its full depth of bytes.
- A source that must not lose data holds `wr_valid` and `wr_data` until `wr_ready` returns.
- A byte offered while `wr_ready` is low is discarded, and a sticky overflow flag is set.

Top module: `uart_dirtx`

## Requirements
- R1: After reset, `txd` is high, `tx_irq`, `ovf_flag` and `dir_out` are low, and `wr_ready` is high. If `auto_dir` is then raised while the block is idle, `dir_out` reads high (receive state).
- R2: A frame is one low start bit, then data bits 0 through 7 in that order, then one high stop bit. Each bit lasts exactly 16 `tick16` pulses counted from the cycle in which `txd` falls. `txd` is high whenever no frame is in progress.
- R3: Accepted bytes leave in acceptance order. A byte that waits in the queue starts its frame without waiting for any further tick.
- R4: The queue holds 16 bytes besides the one in the frame engine. With ticks stopped, 17 back-to-back writes into an empty block are accepted and the 18th is refused. A refused write sets `ovf_flag`, and only reset clears it.
- R5: In standard mode, `tx_irq` rises when the queue becomes empty, while the frame that drained it is still being sent.
- R6: In automatic mode, `tx_irq` rises only once the queue and the frame engine are both empty, never during a frame.
- R7: `tx_irq` is cleared by an `int_ack` pulse or by any accepted write. It sets again on the next qualifying empty event.
- R8: In automatic mode, `dir_out` rises at the 16th tick after the end of the last stop bit. That is 176 ticks after the start-bit fall of the final frame.
- R9: In automatic mode, `dir_out` stays low for the whole of a run of back-to-back frames. No direction delay starts while bytes are still queued at the end of a stop bit.
- R10: An accepted write makes `dir_out` low at the next clock edge. A write during the one-bit delay cancels the delay, so the pin stays low until after the new frame.
- R11: In standard mode, `dir_out` is held low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Queue has room; high when a byte can be taken |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| auto_dir | input | 1 | 1 selects automatic direction mode, 0 selects standard mode |
| int_ack | input | 1 | One-cycle pulse that clears the interrupt |
| txd | output | 1 | Serial output, idles high |
| dir_out | output | 1 | Transceiver direction: low while sending, high in receive state |
| tx_irq | output | 1 | Transmit-empty interrupt |
| ovf_flag | output | 1 | Sticky flag: a write was refused |

## Verification
The assertions check the following on every cycle:
- the queue never holds more than its depth and is never popped when empty;
- a refused write always raises the sticky overflow flag;
- every frame opens with a low start bit and closes with a high stop bit;
- in automatic mode, the direction pin stays low while a frame is active and rises only on a tick;
- in automatic mode, the interrupt never rises while the shifter is busy;
- an accepted write always leaves the interrupt and the direction pin low on the next edge.

The bench scenarios cover what no single-cycle property can show:
- the exact count of 176 ticks from the last start-bit fall to the direction edge;
- cancelling the delay mid-count;
- the 17-accept limit with ticks stopped;
- byte order and bit order decoded from the line;
- in standard mode, an interrupt that lands during the draining frame.

// File: rtl/uart_dirtx_pkg.sv
package uart_dirtx_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/uart_dirtx_fifo.sv
module uart_dirtx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign pop_data = mem[rp];
  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));

  // R4: occupancy never exceeds the depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4: the write side never pushes into a full queue
  p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: the frame engine never takes from an empty queue
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/uart_dirtx_shifter.sv
module uart_dirtx_shifter
  import uart_dirtx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         have_data,
  input  logic [W-1:0] data,
  output logic         take,
  output logic         busy,
  output logic         stop_done,
  output logic         txd
);
  localparam int FB  = W + 2;
  localparam int TCW = $clog2(OSR);
  localparam int BCW = $clog2(FB);

  tx_state_e      state;
  logic [FB-1:0]  sh;
  logic [TCW-1:0] tcnt;
  logic [BCW-1:0] bcnt;
  logic           bit_end;

  assign take      = (state == TX_IDLE) && have_data;
  assign busy      = (state == TX_SEND);
  assign bit_end   = busy && tick && (tcnt == TCW'(OSR - 1));
  assign stop_done = bit_end && (bcnt == BCW'(FB - 1));
  assign txd       = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      sh    <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (state == TX_IDLE) begin
      if (have_data) begin
        sh    <= {1'b1, data, 1'b0};
        tcnt  <= '0;
        bcnt  <= '0;
        state <= TX_SEND;
      end
    end else if (tick) begin
      if (bit_end) begin
        tcnt <= '0;
        if (stop_done) begin
          state <= TX_IDLE;
        end else begin
          sh   <= {1'b1, sh[FB-1:1]};
          bcnt <= bcnt + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R2: a frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R2: the last bit of a frame is a high stop bit
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> txd);
endmodule

// File: rtl/uart_dirtx_dirctl.sv
module uart_dirtx_dirctl #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic auto_dir,
  input  logic accept,
  input  logic stop_done,
  input  logic fifo_empty,
  input  logic busy,
  input  logic int_ack,
  output logic dir_out,
  output logic tx_irq
);
  localparam int DCW = $clog2(OSR + 1);

  logic           dir_q;
  logic           dly_on;
  logic [DCW-1:0] dcnt;
  logic           qual, qual_q, qual_rise;

  // direction delay runs in both modes; only the output is gated by the mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b1;
      dly_on <= 1'b0;
      dcnt   <= '0;
    end else if (accept) begin
      dir_q  <= 1'b0;
      dly_on <= 1'b0;
    end else if (stop_done && fifo_empty) begin
      dly_on <= 1'b1;
      dcnt   <= DCW'(OSR);
    end else if (dly_on && tick) begin
      if (dcnt == DCW'(1)) begin
        dly_on <= 1'b0;
        dir_q  <= 1'b1;
      end else begin
        dcnt <= dcnt - 1'b1;
      end
    end
  end

  assign dir_out   = auto_dir & dir_q;
  assign qual      = fifo_empty && (!auto_dir || !busy);
  assign qual_rise = qual && !qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b1;
      tx_irq <= 1'b0;
    end else begin
      qual_q <= qual;
      if (accept)         tx_irq <= 1'b0;
      else if (qual_rise) tx_irq <= 1'b1;
      else if (int_ack)   tx_irq <= 1'b0;
    end
  end

  // R9: in automatic mode the pin stays low while a frame is on the line
  p_dir_low_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_dir && busy) |-> !dir_out);
  // R8: the direction edge only ever comes on a baud tick
  p_dir_rise_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_q) |-> $past(tick));
  // R6: in automatic mode the interrupt never rises while the shifter works
  p_auto_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_irq) && $past(auto_dir)) |-> (!$past(busy) && $past(fifo_empty)));
endmodule

// File: rtl/uart_dirtx.sv
module uart_dirtx #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         tick16,
  input  logic         auto_dir,
  input  logic         int_ack,
  output logic         txd,
  output logic         dir_out,
  output logic         tx_irq,
  output logic         ovf_flag
);
  logic         accept, full, empty, take, busy, stop_done;
  logic [W-1:0] head;

  assign wr_ready = !full;
  assign accept   = wr_valid && wr_ready;

  uart_dirtx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (wr_data),
    .pop       (take),
    .pop_data  (head),
    .empty     (empty),
    .full      (full)
  );

  uart_dirtx_shifter #(.OSR(OSR), .W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .have_data (!empty),
    .data      (head),
    .take      (take),
    .busy      (busy),
    .stop_done (stop_done),
    .txd       (txd)
  );

  uart_dirtx_dirctl #(.OSR(OSR)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .auto_dir   (auto_dir),
    .accept     (accept),
    .stop_done  (stop_done),
    .fifo_empty (empty),
    .busy       (busy),
    .int_ack    (int_ack),
    .dir_out    (dir_out),
    .tx_irq     (tx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_flag <= 1'b0;
    else if (wr_valid && !wr_ready)  ovf_flag <= 1'b1;
  end

  // R4: a refused write always leaves the overflow flag set
  p_drop_sets_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ovf_flag);
  // R4: the overflow flag is sticky
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  // R7: an accepted write clears the interrupt
  p_write_clears_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_irq);
  // R10: an accepted write pulls the direction pin low
  p_write_drops_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dir_out);
endmodule

// File: tb/uart_dirtx_test.sv
module uart_dirtx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick16 = 1'b0;
  logic       auto_dir = 1'b0;
  logic       int_ack = 1'b0;
  logic       wr_ready, txd, dir_out, tx_irq, ovf_flag;

  always #4 clk = ~clk;

  uart_dirtx uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .tick16(tick16), .auto_dir(auto_dir),
    .int_ack(int_ack), .txd(txd), .dir_out(dir_out), .tx_irq(tx_irq),
    .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] expq[$];
  bit   tick_en = 0, fresh = 0, dec_act = 0, stop_ok = 0;
  int   phase = 0, dec_cnt = 0, since_fall = 0;
  logic [7:0] shreg;
  bit   dir_prev = 0, irq_prev = 0, dir_bad = 0, irq_early = 0, irq_in_frame = 0;
  int   rises = 0, rise_at = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rise(input bit mode);
    return mode ? 11 * 16 : -1;
  endfunction

  task automatic cyc();
    @(negedge clk);
    if (!dec_act && txd == 1'b0) begin
      dec_act = 1; dec_cnt = 0; since_fall = 0;
    end else if (dec_act && fresh) begin
      if (dec_cnt >= 24 && dec_cnt <= 136 && dec_cnt % 16 == 8)
        shreg[dec_cnt / 16 - 1] = txd;
      if (dec_cnt == 152) stop_ok = txd;
      if (dec_cnt == 160) begin
        dec_act = 0;
        if (expq.size() == 0) chk(0, "R3 unexpected frame", shreg, -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(shreg == e && stop_ok, "R2/R3 frame byte", shreg, e);
        end
      end
    end
    if (dir_out && !dir_prev) begin rises++; rise_at = since_fall; end
    if (dir_out && dec_act) dir_bad = 1;
    if (tx_irq && !irq_prev) begin
      if (dec_act || expq.size() != 0) irq_early = 1;
      if (dec_act) irq_in_frame = 1;
    end
    dir_prev = dir_out;
    irq_prev = tx_irq;
    fresh = 0;
    tick16 = tick_en && (phase == 0);
    phase = (phase + 1) % 3;
    if (tick16) begin
      since_fall++;
      if (dec_act) dec_cnt++;
      fresh = 1;
    end
  endtask

  task automatic wr(input logic [7:0] b, output bit acc);
    wr_valid = 1; wr_data = b;
    acc = wr_ready;
    if (acc) expq.push_back(b);
    cyc();
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    while (expq.size() != 0 || dec_act) cyc();
    repeat (70) cyc();
  endtask

  task automatic clear_mon();
    rises = 0; rise_at = -1; dir_bad = 0; irq_early = 0; irq_in_frame = 0;
  endtask

  task automatic ack();
    int_ack = 1; cyc(); int_ack = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit a;
    int acc_n;
    void'($urandom(32'd1234));
    repeat (4) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(txd == 1, "R1 txd idle", txd, 1);
    chk(dir_out == 0 && tx_irq == 0, "R1 dir/irq low", {dir_out, tx_irq}, 0);
    chk(ovf_flag == 0 && wr_ready == 1, "R1 ovf low ready high", {ovf_flag, wr_ready}, 1);
    auto_dir = 1; cyc();
    chk(dir_out == 1, "R1 receive state in auto mode", dir_out, 1);

    // R5 / R11: standard mode, single byte
    auto_dir = 0; tick_en = 1; cyc(); clear_mon(); dir_prev = dir_out;
    wr(8'hA5, a);
    begin
      int g = 0;
      while (!tx_irq && g < 2000) begin cyc(); g++; end
    end
    chk(tx_irq && dec_act, "R5 irq during draining frame", {tx_irq, dec_act}, 3);
    wait_idle();
    chk(rises == 0 && dir_out == 0, "R11 dir low in standard mode", rises, 0);
    ack();
    chk(tx_irq == 0, "R7 ack clears irq", tx_irq, 0);

    // R6 / R8 / R9: automatic mode, back-to-back burst
    auto_dir = 1; cyc(); clear_mon(); dir_prev = dir_out;
    wr(8'h3C, a); wr(8'h81, a); wr(8'h00, a); wr(8'hFF, a);
    wait_idle();
    chk(rises == 1 && rise_at == exp_rise(1), "R8 dir edge 176 ticks after last fall", rise_at, exp_rise(1));
    chk(dir_bad == 0, "R9 dir low across back-to-back frames", dir_bad, 0);
    chk(irq_early == 0 && tx_irq == 1, "R6 irq only after shifter empty", {irq_early, tx_irq}, 1);
    wr(8'h5A, a);
    chk(tx_irq == 0, "R7 write clears irq", tx_irq, 0);
    chk(dir_out == 0, "R10 write drops dir", dir_out, 0);
    wait_idle();
    chk(tx_irq == 1, "R7 irq re-arms", tx_irq, 1);

    // R10: write during the one-bit delay cancels it
    clear_mon();
    wr(8'hC3, a);
    while (dec_act || since_fall < 168) cyc();
    chk(dir_out == 0, "R10 still low mid-delay", dir_out, 0);
    wr(8'h69, a);
    wait_idle();
    chk(rises == 1 && rise_at == exp_rise(1), "R10 delay cancelled then restarted", rise_at, exp_rise(1));

    // R4: capacity and overflow with ticks stopped
    auto_dir = 0; tick_en = 0; ack(); cyc();
    acc_n = 0;
    for (int i = 0; i < 18; i++) begin
      wr(8'(i * 13 + 7), a);
      if (a) acc_n++;
    end
    chk(acc_n == 17, "R4 accepted count", acc_n, 17);
    chk(wr_ready == 0 && ovf_flag == 1, "R4 full and overflow", {wr_ready, ovf_flag}, 1);
    tick_en = 1;
    wait_idle();
    chk(ovf_flag == 1, "R4 overflow sticky", ovf_flag, 1);

    // random bursts in both modes
    for (int b = 0; b < 20; b++) begin
      bit m;
      int len;
      m = 1'($urandom_range(0, 1));
      auto_dir = m; ack(); cyc(); clear_mon(); dir_prev = dir_out;
      len = $urandom_range(1, 5);
      for (int k = 0; k < len; k++) begin
        wr(8'($urandom), a);
        repeat ($urandom_range(0, 20)) cyc();
      end
      wait_idle();
      if (m) begin
        chk(rises == 1 && rise_at == exp_rise(1), "R8 random auto dir edge", rise_at, exp_rise(1));
        chk(dir_bad == 0 && irq_early == 0, "R6/R9 random auto", {dir_bad, irq_early}, 0);
      end else begin
        chk(rises == 0 && dir_out == 0, "R11 random standard dir low", rises, 0);
        chk(irq_in_frame == 1, "R5 random standard irq in frame", irq_in_frame, 1);
      end
      chk(tx_irq == 1, "R7 random irq after drain", tx_irq, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule